// File: doc/BRIEF.md
# CPU Mode and Wake Sequencer

This block decides, one clock at a time, which run state the processor is in: normal run, break, wait or stop. It watches a reset request, a break request, a set of interrupt request lines with per-line enables, and single-cycle strobes raised when the core executes its wait or stop instruction. From the current state it produces the core clock enable and the peripheral clock enable. When the core must jump to a vector, it raises a one-cycle vector-take pulse together with a vector code. It also raises a stacking-start pulse when an interrupt or break entry has to save context, and a one-cycle pulse that tells the core to clear its interrupt mask.

Events are ranked strictly. A reset request beats everything else. A break request beats interrupts and instruction strobes, and it sends the core to the software-interrupt vector. Enabled interrupts come last, and the lowest-numbered enabled source wins. Interrupts only matter while the core is in wait or stop, or in the cycle in which the low-power instruction executes. In normal run, interrupt entry belongs to the core and this block does not take part.

Top module: `cpu_mode_seq`

## Requirements
- R1: After the block reset (rst_n low) the state output reads 0 (run), both clock enables are 1, and vec_take, stack_start and imask_clr are 0. The state codes are 0 run, 1 break, 2 wait and 3 stop.
- R2: A reset request in any state gives, on the next cycle, state 0, vec_take=1, vec_sel=0 and stack_start=0, whatever break, interrupt or instruction inputs are present in the same cycle.
- R3: A break request outside break state, with no reset request, gives on the next cycle state 1, vec_take=1, vec_sel=1 (software-interrupt code) and stack_start=1. It beats interrupts and instruction strobes, and it is taken only once while it stays high.
- R4: In break state, interrupts and wait/stop strobes have no effect, and the state returns to 0 on the cycle after the break request drops.
- R5: A wait or stop strobe in run state, with no reset or break request, gives imask_clr=1 for exactly the next cycle. If both strobes are high, stop is chosen.
- R6: In wait state cpu_clk_en is 0 and per_clk_en is 1.
- R7: In stop state cpu_clk_en and per_clk_en are both 0.
- R8: In wait or stop state, when any request line is high with its enable set, the next cycle shows state 0, vec_take=1, stack_start=1 and vec_sel = 2 + the lowest such line index.
- R9: A request whose enable is clear never wakes the core: in wait or stop state the state holds with no pulses. In run state, request lines alone produce no pulse and no state change.
- R10: A wait or stop strobe with an enabled request in the same cycle gives, on the very next cycle, imask_clr=1 and stack_start=1 with state 0 and the wake vector of R8. The low-power state is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| rst_req | input | 1 | Merged reset-source request |
| brk_req | input | 1 | Break request, held high for the break duration |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| wait_exec | input | 1 | Wait instruction executes this cycle |
| stop_exec | input | 1 | Stop instruction executes this cycle |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | One-cycle interrupt-mask clear pulse |
| vec_take | output | 1 | One-cycle vector fetch pulse |
| vec_sel | output | $clog2(NUM_IRQ+2) | Vector code: 0 reset, 1 software interrupt, 2+i request line i |
| stack_start | output | 1 | One-cycle context stacking start pulse |
| run_state | output | 2 | Current state code |

## Verification
The bench builds the block with its default of four request lines. At that size the bench can sweep all 256 request/enable combinations from both wait and stop, plus every enabled combination in the same cycle as each low-power strobe. Every lowest-index tie in the wake vector is therefore covered, and so is every case where a request is present but disabled. Directed sequences then check the reset-over-break-over-interrupt ranking in each state, and the held break that must be taken only once.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BRK  = 2'd1,
    ST_WAIT = 2'd2,
    ST_STOP = 2'd3
  } run_state_e;

  localparam int VEC_CODE_RESET = 0;
  localparam int VEC_CODE_SWI   = 1;
  localparam int VEC_CODE_IRQ0  = 2;

  function automatic int irq_vec_code(input int line);
    return VEC_CODE_IRQ0 + line;
  endfunction
endpackage

// File: rtl/cms_irq_arbiter.sv
module cms_irq_arbiter #(
  parameter int NUM_IRQ = 4,
  parameter int VEC_W   = 3
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               irq_hit,
  output logic [VEC_W-1:0]   irq_vec
);
  import cms_pkg::*;

  logic [NUM_IRQ-1:0] live;
  assign live    = irq_req & irq_en;
  assign irq_hit = |live;

  // lowest enabled line wins: scan downward so the last match is the lowest
  always_comb begin
    irq_vec = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (live[i]) irq_vec = VEC_W'(irq_vec_code(i));
    end
  end
endmodule

// File: rtl/cms_clk_decode.sv
module cms_clk_decode (
  input  cms_pkg::run_state_e state,
  output logic                cpu_clk_en,
  output logic                per_clk_en
);
  import cms_pkg::*;

  always_comb begin
    cpu_clk_en = 1'b1;
    per_clk_en = 1'b1;
    case (state)
      ST_WAIT: cpu_clk_en = 1'b0;
      ST_STOP: begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cms_mode_ctrl.sv
module cms_mode_ctrl #(
  parameter int VEC_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_req,
  input  logic                brk_req,
  input  logic                wait_exec,
  input  logic                stop_exec,
  input  logic                irq_hit,
  input  logic [VEC_W-1:0]    irq_vec,
  output cms_pkg::run_state_e state,
  output logic                vec_take,
  output logic [VEC_W-1:0]    vec_sel,
  output logic                stack_start,
  output logic                imask_clr
);
  import cms_pkg::*;

  run_state_e       state_n;
  logic             take_n, stack_n, clr_n;
  logic [VEC_W-1:0] sel_n;
  logic             low_power, lp_exec, brk_entry;

  assign low_power = (state == ST_WAIT) || (state == ST_STOP);
  assign lp_exec   = wait_exec || stop_exec;
  assign brk_entry = brk_req && (state != ST_BRK);

  always_comb begin
    state_n = state;
    take_n  = 1'b0;
    stack_n = 1'b0;
    clr_n   = 1'b0;
    sel_n   = vec_sel;
    if (rst_req) begin
      state_n = ST_RUN;
      take_n  = 1'b1;
      sel_n   = VEC_W'(VEC_CODE_RESET);
    end else if (brk_entry) begin
      state_n = ST_BRK;
      take_n  = 1'b1;
      stack_n = 1'b1;
      sel_n   = VEC_W'(VEC_CODE_SWI);
    end else begin
      case (state)
        ST_RUN: begin
          if (lp_exec) begin
            clr_n = 1'b1;
            if (irq_hit) begin
              take_n  = 1'b1;
              stack_n = 1'b1;
              sel_n   = irq_vec;
            end else begin
              state_n = stop_exec ? ST_STOP : ST_WAIT;
            end
          end
        end
        ST_BRK: begin
          if (!brk_req) state_n = ST_RUN;
        end
        default: begin
          if (irq_hit) begin
            state_n = ST_RUN;
            take_n  = 1'b1;
            stack_n = 1'b1;
            sel_n   = irq_vec;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      vec_take    <= 1'b0;
      stack_start <= 1'b0;
      imask_clr   <= 1'b0;
      vec_sel     <= '0;
    end else begin
      state       <= state_n;
      vec_take    <= take_n;
      stack_start <= stack_n;
      imask_clr   <= clr_n;
      vec_sel     <= sel_n;
    end
  end

  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (vec_take && vec_sel == '0 && !stack_start && state == ST_RUN)); // R2
  AST_BRK_TO_SWI: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && brk_entry) |=> (state == ST_BRK && vec_sel == VEC_W'(VEC_CODE_SWI) && stack_start)); // R3
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && state == ST_BRK && brk_req) |=> (state == ST_BRK && !vec_take && !imask_clr)); // R4
  AST_WAKE_STACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !brk_req && low_power && irq_hit) |=> (state == ST_RUN && stack_start && vec_take)); // R8
  AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !brk_req && low_power && !irq_hit) |=> ($stable(state) && !stack_start && !vec_take)); // R9
  AST_SAME_CYCLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !brk_req && state == ST_RUN && lp_exec && irq_hit) |=> (imask_clr && stack_start && state == ST_RUN)); // R10
endmodule

// File: rtl/cpu_mode_seq.sv
module cpu_mode_seq #(
  parameter int NUM_IRQ = 4,
  localparam int VEC_W  = $clog2(NUM_IRQ + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req,
  input  logic               brk_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               wait_exec,
  input  logic               stop_exec,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               imask_clr,
  output logic               vec_take,
  output logic [VEC_W-1:0]   vec_sel,
  output logic               stack_start,
  output logic [1:0]         run_state
);
  import cms_pkg::*;

  logic             irq_hit;
  logic [VEC_W-1:0] irq_vec;
  run_state_e       state;

  cms_irq_arbiter #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) arb_i (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .irq_hit (irq_hit),
    .irq_vec (irq_vec)
  );

  cms_mode_ctrl #(.VEC_W(VEC_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req     (rst_req),
    .brk_req     (brk_req),
    .wait_exec   (wait_exec),
    .stop_exec   (stop_exec),
    .irq_hit     (irq_hit),
    .irq_vec     (irq_vec),
    .state       (state),
    .vec_take    (vec_take),
    .vec_sel     (vec_sel),
    .stack_start (stack_start),
    .imask_clr   (imask_clr)
  );

  cms_clk_decode clk_i (
    .state      (state),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en)
  );

  assign run_state = state;

  AST_WAIT_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (!cpu_clk_en && per_clk_en)); // R6
  AST_STOP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> (!cpu_clk_en && !per_clk_en)); // R7
  AST_ONE_SHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_clr && state != ST_RUN) |=> !imask_clr); // R5
endmodule

// File: tb/cpu_mode_seq_tb.sv
`timescale 1ns/1ps
module cpu_mode_seq_tb_top;
  localparam int NI = 4;
  localparam int VW = $clog2(NI + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 0, brk_req = 0, wait_exec = 0, stop_exec = 0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic cpu_clk_en, per_clk_en, imask_clr, vec_take, stack_start;
  logic [VW-1:0] vec_sel;
  logic [1:0] run_state;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cpu_mode_seq #(.NUM_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .brk_req(brk_req),
    .irq_req(irq_req), .irq_en(irq_en), .wait_exec(wait_exec), .stop_exec(stop_exec),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .imask_clr(imask_clr),
    .vec_take(vec_take), .vec_sel(vec_sel), .stack_start(stack_start), .run_state(run_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    rst_req = 0; brk_req = 0; wait_exec = 0; stop_exec = 0;
    irq_req = '0; irq_en = '0;
  endtask

  // expected wake vector: 2 + index of lowest set bit, from the isolated bit
  function automatic int wake_code(input int m);
    return 2 + $clog2(m & (-m));
  endfunction

  task automatic back_to_run();
    quiet(); rst_req = 1; tick(); rst_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    quiet();
    repeat (2) tick();
    // R1 reset state
    chk("R1 state", run_state, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 per_clk_en", per_clk_en, 1);
    chk("R1 pulses", {vec_take, stack_start, imask_clr}, 0);
    rst_n = 1'b1;
    tick();

    // R9 requests in run state do nothing
    irq_req = '1; irq_en = '1; tick(); quiet();
    chk("R9 run ignores irq state", run_state, 0);
    chk("R9 run ignores irq pulses", {vec_take, stack_start, imask_clr}, 0);

    // R5 R6 R7 R8 R9 R2 sweep from wait (lp=2) and stop (lp=3)
    for (int lp = 2; lp <= 3; lp++) begin
      for (int rq = 0; rq < 16; rq++) begin
        for (int en = 0; en < 16; en++) begin
          if (lp == 2) wait_exec = 1; else stop_exec = 1;
          tick(); quiet();
          chk("R5 imask_clr pulse", imask_clr, 1);
          chk("R5 enters low power", run_state, lp);
          chk("R6 R7 cpu_clk_en", cpu_clk_en, 0);
          chk("R6 R7 per_clk_en", per_clk_en, (lp == 2) ? 1 : 0);
          irq_req = rq; irq_en = en;
          tick(); quiet();
          chk("R5 pulse single", imask_clr, 0);
          if ((rq & en) != 0) begin
            chk("R8 wake state", run_state, 0);
            chk("R8 wake pulses", {vec_take, stack_start}, 3);
            chk("R8 wake vector", vec_sel, wake_code(rq & en));
          end else begin
            chk("R9 no wake state", run_state, lp);
            chk("R9 no wake pulses", {vec_take, stack_start}, 0);
            back_to_run();
            chk("R2 reset from low power", {vec_take, stack_start, 4'(vec_sel)}, 6'b10_0000);
            chk("R2 clocks back", {run_state, cpu_clk_en, per_clk_en}, 4'b0011);
          end
          tick();
        end
      end
    end

    // R10 same-cycle wake, both instructions
    for (int s = 0; s < 2; s++) begin
      for (int en = 1; en < 16; en++) begin
        if (s == 0) wait_exec = 1; else stop_exec = 1;
        irq_req = '1; irq_en = en;
        tick(); quiet();
        chk("R10 imask_clr", imask_clr, 1);
        chk("R10 stack_start", stack_start, 1);
        chk("R10 state run", run_state, 0);
        chk("R10 vector", vec_sel, wake_code(en));
        tick();
      end
    end

    // R5 stop chosen over wait
    wait_exec = 1; stop_exec = 1; tick(); quiet();
    chk("R5 stop wins", run_state, 3);
    back_to_run();

    // R3 break beats irq and strobe, taken once
    brk_req = 1; wait_exec = 1; irq_req = '1; irq_en = '1;
    tick(); wait_exec = 0;
    chk("R3 break state", run_state, 1);
    chk("R3 swi vector", vec_sel, 1);
    chk("R3 break pulses", {vec_take, stack_start, imask_clr}, 3'b110);
    // R4 held break ignores strobes and irqs
    stop_exec = 1; tick(); stop_exec = 0;
    chk("R3 taken once", vec_take, 0);
    chk("R4 strobe ignored", {run_state, imask_clr}, 3'b010);
    tick();
    chk("R4 irq ignored", {run_state, stack_start}, 3'b010);
    brk_req = 0; tick();
    chk("R4 exit break", run_state, 0);
    quiet(); tick();

    // R3 break from wait with enabled irq pending
    wait_exec = 1; tick(); quiet();
    brk_req = 1; irq_req = 4'b0001; irq_en = 4'b0001; tick();
    chk("R3 break beats wake", {run_state, 4'(vec_sel)}, 6'b01_0001);
    quiet(); tick();

    // R2 reset beats break and strobe
    rst_req = 1; brk_req = 1; stop_exec = 1; irq_req = '1; irq_en = '1; tick(); quiet();
    chk("R2 reset wins", {vec_take, stack_start, imask_clr}, 3'b100);
    chk("R2 reset vector", vec_sel, 0);
    chk("R2 reset state", run_state, 0);

    // R2 reset from stop restores clocks
    stop_exec = 1; tick(); quiet();
    chk("R7 stop clocks", {cpu_clk_en, per_clk_en}, 0);
    rst_req = 1; tick(); quiet();
    chk("R2 clocks after stop", {cpu_clk_en, per_clk_en}, 3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule